// File: doc/BRIEF.md
# Waveform Memory Load/Playback Controller

The controller connects a slow microcontroller, an external 16-bit asynchronous SRAM and a 12-bit DAC. One address counter serves both phases of operation. While loading, the host drives a word onto the SRAM data bus, pulses a write control to store it, then pulses a software step line. The step line moves the address on by one. During playback the same counter advances on every cycle of the fast sample clock. The word at each address goes to the DAC, and the address runs continuously around the whole memory, so the stored waveform repeats without gaps.

All logic runs in the fast clock domain. The step and write lines are slow and asynchronous, so each passes through a two-flop synchronizer. The step line is then edge-detected into a single-cycle increment enable, which avoids a clock multiplexer. A mode select picks the counter's increment source. A synchronous clear returns the address to zero. The bus enables ensure that the host-to-SRAM driver and the SRAM read path are never open together.

Top module: `wavemem_ctrl`

## Requirements
- R1: While rst_ni is low, sram_addr_o is 0, dac_data_o is 0, sram_we_no and sram_oe_no are 1, and sram_dq_oe_o is 0.
- R2: ctr_clr_i is synchronous: the clock edge on which it is high sets sram_addr_o to 0. It overrides any increment in both modes.
- R3: With mode_i = 0 (software step), sram_addr_o advances by exactly one for each 0-to-1 transition of sw_step_i, within four clocks, and is otherwise held. The fast clock alone does not move it.
- R4: With mode_i = 0 and host_wr_i held high, within four clocks sram_we_no is 0, sram_dq_oe_o is 1, and sram_dq_o equals host_data_i. With mode_i = 1, host_wr_i is ignored: sram_we_no stays 1 and sram_dq_oe_o stays 0.
- R5: With mode_i = 1 (fast), sram_addr_o increases by one on every clock, and sw_step_i has no effect. After 8191 the next address is 0.
- R6: sram_oe_no is 0 exactly when play_en_i is 1 and the host write path is closed. When both are requested, the write wins, so sram_dq_oe_o and an active read are never present together.
- R7: While the read path is open, the word read at address N reaches dac_data_o one clock after N is on sram_addr_o. dac_data_o carries bits 11:0 of that word, and bits 15:12 are ignored.
- R8: While sram_oe_no is 1, dac_data_o holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Increment source: 0 software step, 1 fast clock |
| ctr_clr_i | input | 1 | Synchronous address clear |
| sw_step_i | input | 1 | Asynchronous software step pulse from the host |
| host_wr_i | input | 1 | Asynchronous host write control, active high |
| play_en_i | input | 1 | Request to open the SRAM-to-DAC path |
| host_data_i | input | 16 | Host data word to store |
| sram_addr_o | output | 13 | SRAM address |
| sram_dq_o | output | 16 | Data driven onto the SRAM bus |
| sram_dq_oe_o | output | 1 | Enable of the host-to-SRAM driver |
| sram_dq_i | input | 16 | Data read from the SRAM bus |
| sram_we_no | output | 1 | SRAM write enable, active low |
| sram_oe_no | output | 1 | SRAM output enable, active low |
| dac_data_o | output | 12 | Registered DAC sample |

## Verification
Two functions can fall in the same clock. The first pair is the synchronous clear and an increment. The bench holds the clear while a software step is synchronized in load mode, then raises it for one cycle in the middle of fast playback. In both cases the address must read zero on the following cycle rather than one more than before. The second pair is a host write request and a playback request made at the same time in load mode. The write must open, the read must stay closed, and the DAC output must hold.

// File: rtl/wavemem_pkg.sv
package wavemem_pkg;
  typedef enum logic {
    MODE_STEP = 1'b0,
    MODE_FAST = 1'b1
  } inc_mode_e;
endpackage

// File: rtl/wm_sync_edge.sv
module wm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else if (s == 0) sync_q[s] <= async_i;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= sync_q[STAGES-1];
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~prev_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R3
endmodule

// File: rtl/wm_addr_ctr.sv
module wm_addr_ctr #(
  parameter int ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  // clear wins over increment; natural wrap at all-ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (clr_i) addr_q <= '0;
    else if (inc_i) addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;

  AST_CLR_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> addr_o == '0); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && addr_o == '1) |=> addr_o == '0); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(addr_o)); // R3
endmodule

// File: rtl/wm_bus_ctrl.sv
module wm_bus_ctrl #(
  parameter int WORD_W = 16,
  parameter int DAC_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fast_sel_i,
  input  logic              wr_req_i,
  input  logic              rd_req_i,
  input  logic [WORD_W-1:0] host_data_i,
  input  logic [WORD_W-1:0] sram_rdata_i,
  output logic [WORD_W-1:0] sram_wdata_o,
  output logic              sram_wdata_oe_o,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [DAC_W-1:0]  dac_data_o
);
  logic             wr_open;
  logic             rd_open;
  logic [DAC_W-1:0] dac_q;

  assign wr_open = wr_req_i & ~fast_sel_i;
  assign rd_open = rd_req_i & ~wr_open;

  assign sram_wdata_o    = host_data_i;
  assign sram_wdata_oe_o = wr_open;
  assign sram_we_no      = ~wr_open;
  assign sram_oe_no      = ~rd_open;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dac_q <= '0;
    else if (rd_open) dac_q <= sram_rdata_i[DAC_W-1:0];
  end

  assign dac_data_o = dac_q;

  AST_BUS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sram_wdata_oe_o && !sram_oe_no)); // R6
  AST_WE_LOAD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_sel_i |-> sram_we_no); // R4
  AST_DAC_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_no |=> dac_data_o == $past(sram_rdata_i[DAC_W-1:0])); // R7
  AST_DAC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_oe_no |=> $stable(dac_data_o)); // R8
endmodule

// File: rtl/wavemem_ctrl.sv
module wavemem_ctrl
  import wavemem_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int WORD_W      = 16,
  parameter int DAC_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              ctr_clr_i,
  input  logic              sw_step_i,
  input  logic              host_wr_i,
  input  logic              play_en_i,
  input  logic [WORD_W-1:0] host_data_i,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [WORD_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [WORD_W-1:0] sram_dq_i,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [DAC_W-1:0]  dac_data_o
);
  inc_mode_e mode;
  logic      step_pulse;
  logic      step_level;
  logic      wr_level;
  logic      wr_rise;
  logic      ctr_inc;

  assign mode = inc_mode_e'(mode_i);

  wm_sync_edge #(.STAGES(SYNC_STAGES)) u_step_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (sw_step_i),
    .level_o (step_level),
    .rise_o  (step_pulse)
  );

  wm_sync_edge #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (host_wr_i),
    .level_o (wr_level),
    .rise_o  (wr_rise)
  );

  assign ctr_inc = (mode == MODE_FAST) ? 1'b1 : step_pulse;

  wm_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctr_clr_i),
    .inc_i  (ctr_inc),
    .addr_o (sram_addr_o)
  );

  wm_bus_ctrl #(.WORD_W(WORD_W), .DAC_W(DAC_W)) u_bus (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .fast_sel_i      (mode == MODE_FAST),
    .wr_req_i        (wr_level),
    .rd_req_i        (play_en_i),
    .host_data_i     (host_data_i),
    .sram_rdata_i    (sram_dq_i),
    .sram_wdata_o    (sram_dq_o),
    .sram_wdata_oe_o (sram_dq_oe_o),
    .sram_we_no      (sram_we_no),
    .sram_oe_no      (sram_oe_no),
    .dac_data_o      (dac_data_o)
  );

  logic unused_sync;
  assign unused_sync = step_level ^ wr_rise;

  AST_FAST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !ctr_clr_i) |=> sram_addr_o == $past(sram_addr_o) + 1'b1); // R5
endmodule

// File: tb/wavemem_ctrl_tb_top.sv
module wavemem_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0, clr = 1'b0, step = 1'b0, wr = 1'b0, play = 1'b0;
  logic [15:0] hdata = 16'h0;
  logic [12:0] addr;
  logic [15:0] dq_o, dq_i;
  logic        dq_oe, we_n, oe_n;
  logic [11:0] dac;

  int n_chk = 0, n_fail = 0;

  // stimulus word and expected DAC code
  localparam logic [27:0] VEC [8] = '{
    {16'hF123, 12'h123}, {16'h0ABC, 12'hABC}, {16'h5FFF, 12'hFFF},
    {16'hA000, 12'h000}, {16'h3800, 12'h800}, {16'hC7FF, 12'h7FF},
    {16'h9001, 12'h001}, {16'h6555, 12'h555}
  };

  logic [15:0] mem [64];
  logic [15:0] exp_mem [64];

  always #5 clk = ~clk;

  wavemem_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .ctr_clr_i(clr),
    .sw_step_i(step), .host_wr_i(wr), .play_en_i(play),
    .host_data_i(hdata), .sram_addr_o(addr), .sram_dq_o(dq_o),
    .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i), .sram_we_no(we_n),
    .sram_oe_no(oe_n), .dac_data_o(dac)
  );

  // SRAM model, aliased on the low address bits
  assign dq_i = oe_n ? 16'hDEAD : mem[addr[5:0]];
  always @(posedge clk) if (!we_n && dq_oe) mem[addr[5:0]] <= dq_o;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic pulse_step();
    step = 1'b1; repeat (4) @(negedge clk);
    step = 1'b0; repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int err;
    int a0;
    logic [11:0] held;
    for (int i = 0; i < 64; i++) begin
      mem[i] = {4'hE, 12'(i * 73)};
      exp_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(addr == 0 && dac == 0 && we_n && oe_n && !dq_oe, "R1", {addr, dac}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // load phase
    mode = 1'b0; clr = 1'b1; @(negedge clk); clr = 1'b0; @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      hdata = VEC[i][27:12];
      wr = 1'b1; repeat (4) @(negedge clk);
      chk(!we_n && dq_oe && dq_o == VEC[i][27:12], "R4", dq_o, VEC[i][27:12]);
      wr = 1'b0; repeat (4) @(negedge clk);
      exp_mem[i] = VEC[i][27:12];
      chk(addr == i, "R3", addr, i);
      pulse_step();
    end
    chk(addr == 8, "R3", addr, 8);
    repeat (20) @(negedge clk);
    chk(addr == 8, "R3", addr, 8);

    // clear held across a step in load mode
    clr = 1'b1; pulse_step(); clr = 1'b0; @(negedge clk);
    chk(addr == 0, "R2", addr, 0);

    // write and read requested together: write wins
    play = 1'b1; wr = 1'b1; hdata = exp_mem[0]; repeat (4) @(negedge clk);
    chk(oe_n && !we_n, "R6", {oe_n, we_n}, 2);
    wr = 1'b0; repeat (4) @(negedge clk);
    chk(!oe_n && we_n, "R6", {oe_n, we_n}, 1);

    // playback
    mode = 1'b1; clr = 1'b1; wr = 1'b1; @(negedge clk); clr = 1'b0;
    err = 0;
    for (int j = 0; j < 8196; j++) begin
      if (j == 100) step = 1'b1;
      if (j == 200) step = 1'b0;
      @(negedge clk);
      if (j < 8) chk(dac == VEC[j][11:0], "R7", dac, VEC[j][11:0]);
      if (j == 8191) chk(addr == 0, "R5", addr, 0);
      if (j == 50) chk(we_n && !dq_oe, "R4", {we_n, dq_oe}, 2);
      if (dac != exp_mem[j % 64][11:0] || addr != 13'((j + 1) % 8192)) err++;
    end
    chk(err == 0, "R5", err, 0);
    wr = 1'b0;

    // clear during fast run
    a0 = int'(addr);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk(addr == 0 && a0 != 0, "R2", addr, 0);
    @(negedge clk);
    chk(addr == 1 && dac == exp_mem[0][11:0], "R7", dac, exp_mem[0][11:0]);

    // read path closed: DAC holds
    held = dac; play = 1'b0; repeat (6) @(negedge clk);
    chk(oe_n && dac == held, "R8", dac, held);

    // reset returns outputs to idle
    rst_n = 1'b0; @(negedge clk);
    chk(addr == 0 && dac == 0 && oe_n && we_n, "R1", {addr, dac}, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule